// File: doc/BRIEF.md
# Indexed Pixel Mixer with Overlay Cursor

This block sits in the scanout path of an 8-bit indexed framebuffer. Each cycle it may accept one pixel, given as an x and y screen coordinate and a colour index. It maps the index through a 256-entry true-colour lookup table. Over that result it draws a 64x64 hardware pointer. The pointer shape is stored as two bits per pixel, and each non-zero code picks one of three pointer colours. A control word can hide the pointer, or force the whole picture to black. The result is a 24-bit RGB value with a valid flag, two cycles after the input.

The lookup table, the pointer colours, the pointer shape, the control word and the pointer position are all loaded through one write port. A 2-bit select on that port picks the target. Fetching pixels from video memory, raster timing and conversion to other host formats belong to neighbouring blocks.

Top module: `pixmix_top`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0. Reset clears every colour table entry, every pointer colour, every shape word, the control word and the position word to zero, so any pixel then produces out_rgb 0.
- R2: out_valid equals the value pix_valid had exactly 2 clock cycles earlier, with gaps in the input stream kept as gaps.
- R3: A pixel outside the pointer is output as the colour table entry selected by pix_index. A colour table write stores red from wr_data[23:16], green from wr_data[15:8] and blue from wr_data[7:0]. out_rgb carries red in [23:16], green in [15:8] and blue in [7:0].
- R4: Let (px, py) be the pointer origin. A pixel (x, y) is a pointer pixel when px <= x < px+64 and py <= y < py+64, computed without wrap-around, so a window near coordinate 4095 does not reach back to small coordinates.
- R5: The shape word for a pointer pixel is word (y-py)*8 + (x-px)/8. Its 2-bit code is bits [2k+1:2k], where k = (x-px) mod 8.
- R6: Code 0 is transparent and shows the colour table entry. Codes 1, 2 and 3 show pointer colour 0, 1 and 2 respectively.
- R7: When bit 23 of the control word is 1, no pixel is a pointer pixel.
- R8: When bit 10 of the control word is 1, every output pixel is 0, whatever the table and pointer contents.
- R9: The position word gives px from bits [23:12] and py from bits [11:0]. Bits [31:24] are ignored.
- R10: The wr_sel encoding is: 0 writes colour table entry wr_addr[7:0], 1 writes pointer colour wr_addr[1:0], 2 writes shape word wr_addr[8:0], 3 writes the control word (wr_addr[0]=0) or the position word (wr_addr[0]=1). A pointer colour write with wr_addr[1:0]=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_sel | input | 2 | Write target select (see R10) |
| wr_addr | input | 9 | Entry or word address within the selected target |
| wr_data | input | 32 | Write data |
| pix_valid | input | 1 | Input pixel present this cycle |
| pix_x | input | 12 | Pixel column |
| pix_y | input | 12 | Pixel row |
| pix_index | input | 8 | Pixel colour index |
| out_valid | output | 1 | Output pixel present |
| out_rgb | output | 24 | Output colour, red in the top byte |

## Verification
The properties assume that configuration writes do not overlap pixel traffic. The control word and the position are sampled in the first stage, and the pointer colours are read in the second stage, so a write in mid-stream would mix old and new settings within one pixel. The stimulus keeps that ordering: each batch of writes finishes before the pixel stream that depends on it starts, and the stream drains before the next batch. The model computes each expected pixel from its own copy of the tables at the moment the pixel enters. The stimulus scans just outside and just inside all four edges of the pointer window, every code slot of a shape word, and a window placed near the top of the coordinate range.

// File: rtl/pixmix_pkg.sv
package pixmix_pkg;

  localparam int CFG_W      = 32;
  localparam int CHAN_W     = 8;
  localparam int RGB_W      = 3 * CHAN_W;
  localparam int CPAL_N     = 3;
  localparam int BLANK_BIT  = 10;
  localparam int CUROFF_BIT = 23;
  localparam int POS_X_LSB  = 12;

  typedef enum logic [1:0] {
    TGT_PAL  = 2'd0,
    TGT_CPAL = 2'd1,
    TGT_PAT  = 2'd2,
    TGT_REG  = 2'd3
  } wr_tgt_e;

endpackage

// File: rtl/pixmix_cfg_store.sv
module pixmix_cfg_store
  import pixmix_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int PAT_W  = 16,
  parameter int PAT_AW = 9,
  parameter int ADDR_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [CFG_W-1:0]        wr_data,
  input  logic                    rd_en,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [PAT_AW-1:0]       rd_pat,
  output logic [RGB_W-1:0]        pal_q,
  output logic [PAT_W-1:0]        pat_q,
  output logic [CPAL_N*RGB_W-1:0] cpal_flat,
  output logic [CFG_W-1:0]        ctrl_q,
  output logic [CFG_W-1:0]        pos_q
);

  localparam int PAL_N = 1 << IDX_W;
  localparam int PAT_N = 1 << PAT_AW;
  localparam int CSEL_W = $clog2(CPAL_N + 1);

  logic [RGB_W-1:0] pal_mem  [PAL_N];
  logic [PAT_W-1:0] pat_mem  [PAT_N];
  logic [RGB_W-1:0] cpal_mem [CPAL_N];

  logic [CFG_W-1:0] ctrl_d, pos_d;
  logic             pal_we, pat_we, cpal_we;
  logic [CSEL_W-1:0] cpal_sel;

  always_comb begin
    pal_we   = wr_en && (wr_sel == TGT_PAL);
    pat_we   = wr_en && (wr_sel == TGT_PAT);
    cpal_sel = wr_addr[CSEL_W-1:0];
    cpal_we  = wr_en && (wr_sel == TGT_CPAL) && (int'(cpal_sel) < CPAL_N);
    ctrl_d   = ctrl_q;
    pos_d    = pos_q;
    if (wr_en && (wr_sel == TGT_REG)) begin
      if (wr_addr[0]) pos_d  = wr_data;
      else            ctrl_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pos_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      pos_q  <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAL_N; i++) pal_mem[i] <= '0;
    end else if (pal_we) begin
      pal_mem[wr_addr[IDX_W-1:0]] <= wr_data[RGB_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAT_N; i++) pat_mem[i] <= '0;
    end else if (pat_we) begin
      pat_mem[wr_addr[PAT_AW-1:0]] <= wr_data[PAT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CPAL_N; i++) cpal_mem[i] <= '0;
    end else if (cpal_we) begin
      cpal_mem[cpal_sel] <= wr_data[RGB_W-1:0];
    end
  end

  // Synchronous read ports, enabled only for real pixels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pal_q <= '0;
      pat_q <= '0;
    end else if (rd_en) begin
      pal_q <= pal_mem[rd_idx];
      pat_q <= pat_mem[rd_pat];
    end
  end

  for (genvar g = 0; g < CPAL_N; g++) begin : g_cpal_out
    assign cpal_flat[g*RGB_W +: RGB_W] = cpal_mem[g];
  end

  // R10: the unused pointer colour slot must not alter any stored colour
  p_cpal_hole_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == TGT_CPAL && wr_addr[1:0] == 2'd3) |=> $stable(cpal_flat));

  // R10: a control write is visible on the next cycle
  p_ctrl_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == TGT_REG && !wr_addr[0]) |=> (ctrl_q == $past(wr_data)));

endmodule

// File: rtl/pixmix_cursor_map.sv
module pixmix_cursor_map #(
  parameter int COORD_W = 12,
  parameter int CUR_LOG = 6,
  parameter int SLOT_W  = 3,
  parameter int PAT_AW  = 9
) (
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [COORD_W-1:0] org_x,
  input  logic [COORD_W-1:0] org_y,
  input  logic               cur_off,
  output logic               hit,
  output logic [PAT_AW-1:0]  word_addr,
  output logic [SLOT_W-1:0]  slot
);

  logic [COORD_W:0] dx, dy;
  logic             in_x, in_y;

  always_comb begin
    // One extra bit keeps the borrow, so x < org_x is detected without wrap.
    dx   = {1'b0, x} - {1'b0, org_x};
    dy   = {1'b0, y} - {1'b0, org_y};
    in_x = !dx[COORD_W] && (dx[COORD_W-1:CUR_LOG] == '0);
    in_y = !dy[COORD_W] && (dy[COORD_W-1:CUR_LOG] == '0);
    hit  = in_x && in_y && !cur_off;
    word_addr = {dy[CUR_LOG-1:0], dx[CUR_LOG-1:SLOT_W]};
    slot      = dx[SLOT_W-1:0];
  end

endmodule

// File: rtl/pixmix_out_stage.sv
module pixmix_out_stage
  import pixmix_pkg::*;
#(
  parameter int PAT_W  = 16,
  parameter int CODE_W = 2,
  parameter int SLOT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s1_valid,
  input  logic                    s1_blank,
  input  logic                    s1_hit,
  input  logic [SLOT_W-1:0]       s1_slot,
  input  logic [RGB_W-1:0]        pal_q,
  input  logic [PAT_W-1:0]        pat_q,
  input  logic [CPAL_N*RGB_W-1:0] cpal_flat,
  output logic                    out_valid,
  output logic [RGB_W-1:0]        out_rgb
);

  logic [CODE_W-1:0] code;
  logic [RGB_W-1:0]  cur_rgb;
  logic [RGB_W-1:0]  rgb_d;
  logic              valid_d;

  always_comb begin
    code    = pat_q[int'(s1_slot) * CODE_W +: CODE_W];
    cur_rgb = pal_q;
    for (int k = 0; k < CPAL_N; k++) begin
      if (code == CODE_W'(k + 1)) cur_rgb = cpal_flat[k*RGB_W +: RGB_W];
    end
    valid_d = s1_valid;
    rgb_d   = out_rgb;
    if (s1_valid) begin
      if (s1_blank)    rgb_d = '0;
      else if (s1_hit) rgb_d = cur_rgb;
      else             rgb_d = pal_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= valid_d;
      if (s1_valid) out_rgb <= rgb_d;
    end
  end

  // R8: blanking overrides all table contents
  p_blank_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_blank) |=> (out_rgb == '0));

  // R6: transparent or outside pixels pass the table colour through
  p_transparent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_blank && (!s1_hit || code == '0)) |=> (out_rgb == $past(pal_q)));

  // R6: code n selects pointer colour n-1
  p_code_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_blank && s1_hit && code == CODE_W'(1))
      |=> (out_rgb == $past(cpal_flat[RGB_W-1:0])));

endmodule

// File: rtl/pixmix_top.sv
module pixmix_top
  import pixmix_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int COORD_W = 12,
  parameter int CUR_LOG = 6,
  parameter int PAT_W   = 16,
  parameter int CODE_W  = 2,
  parameter int SLOT_W  = $clog2(PAT_W / CODE_W),
  parameter int PAT_AW  = 2 * CUR_LOG - SLOT_W,
  parameter int ADDR_W  = (PAT_AW > IDX_W) ? PAT_AW : IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               pix_valid,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [IDX_W-1:0]   pix_index,
  output logic               out_valid,
  output logic [23:0]        out_rgb
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [RGB_W-1:0]        pal_q;
  logic [PAT_W-1:0]        pat_q;
  logic [CPAL_N*RGB_W-1:0] cpal_flat;
  logic [CFG_W-1:0]        ctrl_q, pos_q;
  logic [COORD_W-1:0]      org_x, org_y;
  logic                    map_hit;
  logic [PAT_AW-1:0]       map_addr;
  logic [SLOT_W-1:0]       map_slot;

  assign org_x = pos_q[POS_X_LSB +: COORD_W];
  assign org_y = pos_q[COORD_W-1:0];

  pixmix_cfg_store #(
    .IDX_W (IDX_W),
    .PAT_W (PAT_W),
    .PAT_AW(PAT_AW),
    .ADDR_W(ADDR_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (pix_valid),
    .rd_idx   (pix_index),
    .rd_pat   (map_addr),
    .pal_q    (pal_q),
    .pat_q    (pat_q),
    .cpal_flat(cpal_flat),
    .ctrl_q   (ctrl_q),
    .pos_q    (pos_q)
  );

  pixmix_cursor_map #(
    .COORD_W(COORD_W),
    .CUR_LOG(CUR_LOG),
    .SLOT_W (SLOT_W),
    .PAT_AW (PAT_AW)
  ) u_map (
    .x        (pix_x),
    .y        (pix_y),
    .org_x    (org_x),
    .org_y    (org_y),
    .cur_off  (ctrl_q[CUROFF_BIT]),
    .hit      (map_hit),
    .word_addr(map_addr),
    .slot     (map_slot)
  );

  // Stage 1: align pixel attributes with the synchronous table reads.
  logic              s1_valid, s1_blank, s1_hit;
  logic [SLOT_W-1:0] s1_slot;
  logic              s1_valid_d, s1_blank_d, s1_hit_d;
  logic [SLOT_W-1:0] s1_slot_d;

  always_comb begin
    s1_valid_d = pix_valid;
    s1_blank_d = s1_blank;
    s1_hit_d   = s1_hit;
    s1_slot_d  = s1_slot;
    if (pix_valid) begin
      s1_blank_d = ctrl_q[BLANK_BIT];
      s1_hit_d   = map_hit;
      s1_slot_d  = map_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid <= 1'b0;
      s1_blank <= 1'b0;
      s1_hit   <= 1'b0;
      s1_slot  <= '0;
    end else begin
      s1_valid <= s1_valid_d;
      s1_blank <= s1_blank_d;
      s1_hit   <= s1_hit_d;
      s1_slot  <= s1_slot_d;
    end
  end

  pixmix_out_stage #(
    .PAT_W (PAT_W),
    .CODE_W(CODE_W),
    .SLOT_W(SLOT_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .s1_valid (s1_valid),
    .s1_blank (s1_blank),
    .s1_hit   (s1_hit),
    .s1_slot  (s1_slot),
    .pal_q    (pal_q),
    .pat_q    (pat_q),
    .cpal_flat(cpal_flat),
    .out_valid(out_valid),
    .out_rgb  (out_rgb)
  );

  // R2: every accepted pixel appears two cycles later, gaps stay gaps
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pix_valid |-> ##2 out_valid);
  p_gap_lat_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pix_valid |-> ##2 !out_valid);

  // R7: the disable bit suppresses every pointer hit
  p_cursor_off_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_q[CUROFF_BIT] |-> !map_hit);

  // R4: a hit never lies above or left of the origin
  p_hit_window_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    map_hit |-> ((pix_x >= org_x) && (pix_y >= org_y)));

  // R1: nothing leaves the block while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync_n |=> !out_valid);

endmodule

// File: tb/sim_pixmix_top.sv
module sim_pixmix_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [8:0]  wr_addr;
  logic [31:0] wr_data;
  logic        pix_valid;
  logic [11:0] pix_x, pix_y;
  logic [7:0]  pix_index;
  logic        out_valid;
  logic [23:0] out_rgb;

  always #2.5 clk = ~clk;

  pixmix_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .pix_index(pix_index),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );

  // Behavioural model state
  logic [23:0] m_pal  [256];
  logic [23:0] m_cpal [3];
  logic [15:0] m_pat  [512];
  logic [31:0] m_ctrl, m_pos;

  bit          q_v   [$];
  logic [23:0] q_rgb [$];
  string       q_tag [$];

  int n_vec = 0;
  int n_bad = 0;

  function automatic logic [23:0] ref_rgb(int x, int y, int idx);
    int cx, cy, dx, dy, code;
    logic [15:0] w;
    if (m_ctrl[10]) return 24'h0;
    cx = int'(m_pos[23:12]);
    cy = int'(m_pos[11:0]);
    dx = x - cx;
    dy = y - cy;
    if (!m_ctrl[23] && dx >= 0 && dx < 64 && dy >= 0 && dy < 64) begin
      w    = m_pat[dy * 8 + dx / 8];
      code = int'((w >> ((dx % 8) * 2)) & 16'h3);
      if (code != 0) return m_cpal[code - 1];
    end
    return m_pal[idx];
  endfunction

  task automatic check_front();
    bit          ev;
    logic [23:0] er;
    string       et;
    ev = q_v.pop_front();
    er = q_rgb.pop_front();
    et = q_tag.pop_front();
    n_vec++;
    if (out_valid !== ev) begin
      n_bad++;
      $display("FAIL %s out_valid got %b exp %b", et, out_valid, ev);
    end else if (ev && out_rgb !== er) begin
      n_bad++;
      $display("FAIL %s out_rgb got %h exp %h", et, out_rgb, er);
    end
  endtask

  task automatic step(bit v, int x, int y, int idx,
                      bit w, int sel, int addr, logic [31:0] data, string tag);
    @(negedge clk);
    check_front();
    pix_valid = v;
    pix_x     = 12'(x);
    pix_y     = 12'(y);
    pix_index = 8'(idx);
    wr_en     = w;
    wr_sel    = 2'(sel);
    wr_addr   = 9'(addr);
    wr_data   = data;
    q_v.push_back(v);
    q_rgb.push_back(v ? ref_rgb(x, y, idx) : 24'h0);
    q_tag.push_back(tag);
    if (w) begin
      case (sel)
        0: m_pal[addr & 255] = data[23:0];
        1: if ((addr & 3) < 3) m_cpal[addr & 3] = data[23:0];
        2: m_pat[addr & 511] = data[15:0];
        default: if (addr & 1) m_pos = data; else m_ctrl = data;
      endcase
    end
  endtask

  task automatic pix(int x, int y, int idx, string tag);
    step(1'b1, x, y, idx, 1'b0, 0, 0, 32'h0, tag);
  endtask

  task automatic wr(int sel, int addr, logic [31:0] data, string tag);
    step(1'b0, 0, 0, 0, 1'b1, sel, addr, data, tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 1'b0, 0, 0, 32'h0, tag);
  endtask

  task automatic scan_window(int ox, int oy, string tag);
    int ys [6];
    ys = '{oy - 1, oy, oy + 1, oy + 30, oy + 63, oy + 64};
    for (int j = 0; j < 6; j++)
      for (int x = ox - 3; x < ox + 68; x++)
        if (x >= 0 && x < 4096 && ys[j] >= 0 && ys[j] < 4096)
          pix(x, ys[j], (x * 13 + j) & 255, tag);
    idle(2, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) m_pal[i] = '0;
    for (int i = 0; i < 512; i++) m_pat[i] = '0;
    for (int i = 0; i < 3; i++)   m_cpal[i] = '0;
    m_ctrl = '0;
    m_pos  = '0;
    rst_n = 1'b0;
    wr_en = 1'b0; wr_sel = '0; wr_addr = '0; wr_data = '0;
    pix_valid = 1'b0; pix_x = '0; pix_y = '0; pix_index = '0;
    repeat (4) @(negedge clk);
    // R1: no output while reset is held
    n_vec++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 out_valid in reset got %b exp 0", out_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    q_v.push_back(1'b0); q_rgb.push_back('0); q_tag.push_back("R1");
    q_v.push_back(1'b0); q_rgb.push_back('0); q_tag.push_back("R1");

    // R1: cleared tables give black everywhere, including pointer origin
    for (int i = 0; i < 40; i++) pix(i * 3, i, (i * 37) & 255, "R1");
    idle(2, "R1");

    // R3: colour table lookup with byte placement
    for (int i = 0; i < 256; i++)
      wr(0, i, {8'hA5, 8'((i * 7) & 255), 8'(i ^ 8'h5a), 8'(~i)}, "R3");
    idle(1, "R3");
    for (int i = 0; i < 80; i++) pix(200 + i, 300, int'($urandom_range(0, 255)), "R3");
    idle(2, "R3");

    // R2: stream with gaps
    for (int i = 0; i < 120; i++) begin
      if ($urandom_range(0, 2) == 0) step(1'b0, 0, 0, 0, 1'b0, 0, 0, 32'h0, "R2");
      else pix(500 + i, 700, int'($urandom_range(0, 255)), "R2");
    end
    idle(2, "R2");

    // R4 R5 R6: load shape and pointer colours, place pointer at (100,50)
    for (int i = 0; i < 512; i++) wr(2, i, 32'((i * 40503 + 4660) & 16'hffff), "R5");
    wr(1, 0, 32'h00112233, "R6");
    wr(1, 1, 32'h00445566, "R6");
    wr(1, 2, 32'h00778899, "R6");
    wr(3, 1, (32'd100 << 12) | 32'd50, "R9");
    idle(1, "R4");
    scan_window(100, 50, "R4/R5/R6");

    // R10: write to the unused pointer colour slot changes nothing
    wr(1, 3, 32'h00ffffff, "R10");
    idle(1, "R10");
    scan_window(100, 50, "R10");

    // R7: pointer disabled
    wr(3, 0, 32'h0080_0000, "R7");
    idle(1, "R7");
    scan_window(100, 50, "R7");

    // R8: forced blank, with pointer enabled and disabled
    wr(3, 0, 32'h0000_0400, "R8");
    idle(1, "R8");
    scan_window(100, 50, "R8");
    wr(3, 0, 32'h0080_0400, "R8");
    idle(1, "R8");
    for (int i = 0; i < 30; i++) pix(i, i, i, "R8");
    idle(2, "R8");
    wr(3, 0, 32'h0, "R8");

    // R9: upper position bits ignored
    wr(3, 1, 32'h8800_0000 | (32'd200 << 12) | 32'd300, "R9");
    idle(1, "R9");
    scan_window(200, 300, "R9");

    // R4: window near the top of the coordinate range must not wrap
    wr(3, 1, (32'd4090 << 12) | 32'd4090, "R4");
    idle(1, "R4");
    for (int j = 0; j < 4; j++) begin
      int yy;
      yy = (j < 2) ? 4094 + j : j - 2;
      for (int k = 0; k < 6; k++) begin
        int xx;
        xx = (k < 3) ? 4089 + 3 * k : k - 3;
        pix(xx, yy, (xx + yy) & 255, "R4");
      end
    end
    idle(2, "R4");

    // Cursor at origin, covering slot boundaries of every word in row 0
    wr(3, 1, 32'h0, "R5");
    idle(1, "R5");
    for (int x = 0; x < 70; x++) pix(x, 0, x, "R5");
    idle(2, "R5");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule